// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into memory under the control of a ring of descriptors. Each descriptor is four 32-bit words: status, control, buffer address and next pointer. The engine never reads the next pointer. The ring starts at a base address that software programs. When a frame begins, the engine reads the current descriptor. If software has handed that descriptor to hardware, the engine stores the frame one byte at a time from the buffer address. It then writes a status word back, which returns the descriptor to software, and moves to the next descriptor. After a descriptor marked end-of-ring, the next descriptor is the one at the ring base.

If the current descriptor still belongs to software, the engine consumes the whole frame without writing anything and raises a sticky missed-frame flag. The descriptor pointer does not move in that case.

A small register port holds the receive enable, the ring base and a self-clearing software reset. It also returns a status word that reports the engine's process state and the missed-frame flag. The memory port is word addressed and always ready. A read returns its data on the cycle after the request.

The incoming stream is valid/ready. Its rules for back-pressure are these:
- A byte transfers on a clock edge where both `rx_valid` and `rx_ready` are high.
- The source must hold the byte, `rx_last` and `rx_err` stable until that edge.
- `rx_ready` is low while the engine is stopped, while it is idle and while it fetches a descriptor.
- `rx_ready` is high for every cycle in which the engine is storing or discarding a frame.

Top module: `rxring_dma`

## Requirements
- R1: After reset, the status register (selector 3) reads zero, `rx_ready` is low and the engine makes no memory access.
- R2: Reception is enabled by bit 1 of the operation register (selector 1). While it is clear and the engine is idle, `rx_ready` stays low and bits 19:17 of the status register read 0. While it is set and no frame is in progress, those bits read 3'b011.
- R3: For an owned descriptor, the engine writes frame byte i to byte address buffer+i. Each such write sets exactly one byte enable, for lane (buffer+i) mod 4, and this holds for unaligned buffers too.
- R4: The writeback status word has the following layout:
  - bit 31 (ownership) is 0;
  - bits 27:16 hold the number of stored bytes, which includes the 4-byte frame check sequence carried in the stream;
  - bit 8 (last descriptor) is 1;
  - bit 15 (error summary) is 0 for a clean frame.
- R5: The status writeback, to the descriptor's first word, is the last memory write of each frame.
- R6: After a frame, the next frame uses the descriptor 16 bytes further on.
- R7: After a descriptor whose control bit 25 (end of ring) is set, the next frame uses the descriptor at the ring base (selector 2).
- R8: A frame arriving while the current descriptor has bit 31 clear is consumed and leaves memory untouched. It sets status bit 16 (missed frame), which stays set, and the same descriptor is tried for the next frame.
- R9: A frame with `rx_err` high on any byte is still stored, and its writeback sets bit 15.
- R10: Control bits 10:0 give the buffer size. Bytes past the size are not written, the length field reports the size, and bit 15 is set.
- R11: Writing bit 0 of the bus-mode register (selector 0) clears the enable, the ring base, the missed flag and the engine state. The reset bit reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register selector: 0 bus mode, 1 operation, 2 ring base, 3 status |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_sel`, combinational |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Engine accepts a byte |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_err | input | 1 | Frame error marker, sampled on every byte |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 30 | Word address (byte address bits 31:2) |
| mem_be | output | 4 | Byte enables for a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |

## Verification
Register writes take effect at the clock edge that samples them. The status field can therefore be read half a cycle later, and the bench reads it in that place.

A frame start is seen in the idle state. Four fetch cycles follow before `rx_ready` rises, so the bench samples `rx_ready` one time unit after each falling edge. It counts a byte as sent only after a rising edge on which ready was observed high. The writeback happens on the edge after the one that takes the last byte. The bench waits three cycles after the last byte before it reads memory, the write log or the status register. A missed-frame flag is set on the same edge as the dropped frame's last byte, so it is also visible at that point.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    FSM_IDLE, FSM_RD_ST, FSM_RD_CTL, FSM_RD_BUF,
    FSM_LD_BUF, FSM_RECV, FSM_DROP, FSM_WB
  } rx_fsm_t;

  localparam int OWN_BIT   = 31;
  localparam int EOR_BIT   = 25;
  localparam int ES_BIT    = 15;
  localparam int LS_BIT    = 8;
  localparam int LEN_LSB   = 16;
  localparam int RUN_EN_BIT = 1;
  localparam int SRST_BIT  = 0;
  localparam int STATE_LSB = 17;
  localparam int MISS_BIT  = 16;

  localparam logic [1:0] SEL_BUS  = 2'd0;
  localparam logic [1:0] SEL_OP   = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam logic [2:0] PS_STOPPED = 3'b000;
  localparam logic [2:0] PS_FETCH   = 3'b001;
  localparam logic [2:0] PS_WAIT    = 3'b011;
  localparam logic [2:0] PS_CLOSE   = 3'b101;
  localparam logic [2:0] PS_MOVE    = 3'b111;
endpackage

// File: rtl/rxr_csr.sv
module rxr_csr
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic [2:0]        proc_state,
  input  logic              miss_pulse,
  output logic              run_en,
  output logic              soft_rst,
  output logic              base_ld,
  output logic [ADDR_W-1:0] base_val
);
  logic              run_en_q;
  logic              missed_q;
  logic [ADDR_W-1:0] base_q;

  assign soft_rst = csr_we && (csr_sel == SEL_BUS) && csr_wdata[SRST_BIT];
  assign base_ld  = csr_we && (csr_sel == SEL_BASE);
  assign base_val = csr_wdata[ADDR_W-1:0];
  assign run_en   = run_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en_q <= 1'b0;
      missed_q <= 1'b0;
      base_q   <= '0;
    end else if (soft_rst) begin
      run_en_q <= 1'b0;
      missed_q <= 1'b0;
      base_q   <= '0;
    end else begin
      if (csr_we && csr_sel == SEL_OP) run_en_q <= csr_wdata[RUN_EN_BIT];
      if (base_ld) base_q <= base_val;
      if (miss_pulse) missed_q <= 1'b1;
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_sel)
      SEL_OP:   csr_rdata[RUN_EN_BIT] = run_en_q;
      SEL_BASE: csr_rdata[ADDR_W-1:0] = base_q;
      SEL_STAT: begin
        csr_rdata[STATE_LSB +: 3] = proc_state;
        csr_rdata[MISS_BIT]       = missed_q;
      end
      default:  csr_rdata = '0;
    endcase
  end

  assert_srst_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!run_en_q && !missed_q && base_q == '0));

  assert_missed_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_q && !soft_rst) |=> missed_q);
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              run_en,
  input  logic              base_ld,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  input  logic              s_err,
  output logic              s_ready,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              miss_pulse,
  output logic [2:0]        proc_state
);
  localparam int WA    = ADDR_W - 2;
  localparam int CNT_W = SIZE_W + 1;
  localparam int LANES = 4;
  localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(16);

  rx_fsm_t           fsm_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] buf_q;
  logic [SIZE_W-1:0] size_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              own_q, eor_q, err_q, ovf_q;

  logic [WA-1:0]     cur_w;
  logic [ADDR_W-1:0] byte_addr;
  logic [1:0]        lane;
  logic              room;
  logic              take;
  logic [31:0]       wb_word;

  assign cur_w     = cur_q[ADDR_W-1:2];
  assign byte_addr = buf_q + ADDR_W'(cnt_q);
  assign lane      = byte_addr[1:0];
  assign room      = cnt_q < {1'b0, size_q};
  assign s_ready   = (fsm_q == FSM_RECV) || (fsm_q == FSM_DROP);
  assign take      = s_valid && s_ready;
  assign miss_pulse = (fsm_q == FSM_DROP) && take && s_last;

  always_comb begin
    wb_word = '0;
    wb_word[LEN_LSB +: CNT_W] = cnt_q;
    wb_word[ES_BIT]  = err_q || ovf_q;
    wb_word[LS_BIT]  = 1'b1;
    wb_word[OWN_BIT] = 1'b0;
  end

  // byte lanes: replicate data, enable the addressed lane only
  logic [3:0]  lane_be;
  logic [31:0] lane_data;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_be[g]           = (lane == 2'(g));
    assign lane_data[8*g +: 8]  = s_data;
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_w;
    mem_be    = 4'h0;
    mem_wdata = '0;
    case (fsm_q)
      FSM_RD_ST:  mem_en = 1'b1;
      FSM_RD_CTL: begin mem_en = 1'b1; mem_addr = cur_w + WA'(1); end
      FSM_RD_BUF: begin mem_en = 1'b1; mem_addr = cur_w + WA'(2); end
      FSM_RECV: if (take && room) begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = byte_addr[ADDR_W-1:2];
        mem_be    = lane_be;
        mem_wdata = lane_data;
      end
      FSM_WB: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'hF;
        mem_wdata = wb_word;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (fsm_q)
      FSM_IDLE:                          proc_state = run_en ? PS_WAIT : PS_STOPPED;
      FSM_RD_ST, FSM_RD_CTL, FSM_RD_BUF,
      FSM_LD_BUF:                        proc_state = PS_FETCH;
      FSM_WB:                            proc_state = PS_CLOSE;
      default:                           proc_state = PS_MOVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= FSM_IDLE;
      cur_q  <= '0;
      buf_q  <= '0;
      size_q <= '0;
      cnt_q  <= '0;
      own_q  <= 1'b0;
      eor_q  <= 1'b0;
      err_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (soft_rst) begin
      fsm_q <= FSM_IDLE;
      cur_q <= '0;
    end else begin
      if (base_ld) cur_q <= base_val;
      case (fsm_q)
        FSM_IDLE:   if (run_en && s_valid) fsm_q <= FSM_RD_ST;
        FSM_RD_ST:  fsm_q <= FSM_RD_CTL;
        FSM_RD_CTL: begin
          own_q <= mem_rdata[OWN_BIT];
          fsm_q <= FSM_RD_BUF;
        end
        FSM_RD_BUF: begin
          eor_q  <= mem_rdata[EOR_BIT];
          size_q <= mem_rdata[SIZE_W-1:0];
          fsm_q  <= FSM_LD_BUF;
        end
        FSM_LD_BUF: begin
          buf_q <= mem_rdata[ADDR_W-1:0];
          cnt_q <= '0;
          err_q <= 1'b0;
          ovf_q <= 1'b0;
          fsm_q <= own_q ? FSM_RECV : FSM_DROP;
        end
        FSM_RECV: if (take) begin
          if (room) cnt_q <= cnt_q + CNT_W'(1);
          else      ovf_q <= 1'b1;
          if (s_err) err_q <= 1'b1;
          if (s_last) fsm_q <= FSM_WB;
        end
        FSM_DROP: if (take && s_last) fsm_q <= FSM_IDLE;
        FSM_WB: begin
          cur_q <= eor_q ? base_val_q_or_base() : cur_q + DESC_STEP;
          fsm_q <= FSM_IDLE;
        end
        default: fsm_q <= FSM_IDLE;
      endcase
    end
  end

  // ring base shadow, loaded with the base register
  logic [ADDR_W-1:0] ring_base_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ring_base_q <= '0;
    else if (soft_rst)  ring_base_q <= '0;
    else if (base_ld)   ring_base_q <= base_val;
  end

  function automatic logic [ADDR_W-1:0] base_val_q_or_base();
    return ring_base_q;
  endfunction

  assert_wb_own_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && mem_be == 4'hF) |-> !mem_wdata[OWN_BIT]);

  assert_byte_store_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

  assert_drop_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == FSM_DROP) |-> !mem_we);

  assert_stopped_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && proc_state == PS_STOPPED) |-> !s_ready);

  assert_store_within_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == FSM_RECV || fsm_q == FSM_WB) |-> (cnt_q <= {1'b0, size_q}));

  assert_wb_then_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == FSM_WB && !soft_rst) |=> !mem_we);
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  logic              run_en, soft_rst, base_ld, miss_pulse;
  logic [ADDR_W-1:0] base_val;
  logic [2:0]        proc_state;

  rxr_csr #(.ADDR_W(ADDR_W)) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_we     (csr_we),
    .csr_sel    (csr_sel),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .proc_state (proc_state),
    .miss_pulse (miss_pulse),
    .run_en     (run_en),
    .soft_rst   (soft_rst),
    .base_ld    (base_ld),
    .base_val   (base_val)
  );

  rxr_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .run_en     (run_en),
    .base_ld    (base_ld),
    .base_val   (base_val),
    .s_valid    (rx_valid),
    .s_data     (rx_data),
    .s_last     (rx_last),
    .s_err      (rx_err),
    .s_ready    (rx_ready),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .miss_pulse (miss_pulse),
    .proc_state (proc_state)
  );
endmodule

// File: tb/test_rxring_dma.sv
`timescale 1ns/1ps
module test_rxring_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        mem_en, mem_we;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int n_tests = 0, n_fail = 0;
  int wr_cnt = 0;
  logic [29:0] last_wr_addr = '0;
  logic [31:0] last_wr_data = '0;
  logic [31:0] mem [0:1023];
  bit done = 0;

  localparam int BASE = 32'h40;

  always #5 clk = ~clk;

  rxring_dma i_rxring_dma (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:0]][8*b +: 8] = mem_wdata[8*b +: 8];
      wr_cnt++;
      last_wr_addr = mem_addr;
      last_wr_data = mem_wdata;
    end else if (mem_en) begin
      mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  function automatic logic [7:0] mbyte(int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic csr_write(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    csr_sel = sel;
    #1 d = csr_rdata;
  endtask

  task automatic put_desc(int idx, bit own, bit eor, int size, int bufa);
    mem[(BASE >> 2) + 4*idx + 0] = {own, 31'd0};
    mem[(BASE >> 2) + 4*idx + 1] = (32'(eor) << 25) | 32'(size);
    mem[(BASE >> 2) + 4*idx + 2] = 32'(bufa);
    mem[(BASE >> 2) + 4*idx + 3] = 32'h0;
  endtask

  task automatic send_frame(int n, logic [7:0] seed, int err_at);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = seed + 8'(i);
      rx_last = (i == n - 1); rx_err = (i == err_at);
      #1;
      while (!rx_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    csr_read(2'd3, d);
    check("R1", "status after reset", d, 32'h0);
    check("R1", "ready after reset", {31'd0, rx_ready}, 32'h0);
    check("R1", "no memory writes", wr_cnt, 0);
  endtask

  task automatic t_stopped();
    logic [31:0] d;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'h5A;
      #1 check("R2", "ready while stopped", {31'd0, rx_ready}, 32'h0);
    end
    rx_valid = 1'b0;
    csr_read(2'd3, d);
    check("R2", "state while stopped", {29'd0, d[19:17]}, 32'h0);
    check("R2", "no writes while stopped", wr_cnt, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    csr_write(2'd1, 32'h2);
    csr_read(2'd3, d);
    check("R2", "state enabled idle", {29'd0, d[19:17]}, 32'd3);
  endtask

  task automatic t_basic();
    send_frame(10, 8'h10, -1);
    for (int i = 0; i < 10; i++)
      check("R3", $sformatf("byte %0d at unaligned buffer", i), {24'd0, mbyte(32'h402 + i)}, 32'h10 + i);
    check("R3", "byte before buffer untouched", {24'd0, mbyte(32'h401)}, 32'hEE);
    check("R4", "writeback clean 10 bytes incl FCS", mem[BASE >> 2], 32'h000A_0100);
    check("R5", "last write addr is status word", {2'b0, last_wr_addr}, BASE >> 2);
    check("R5", "last write own clear", {31'd0, last_wr_data[31]}, 32'h0);
  endtask

  task automatic t_error();
    send_frame(6, 8'h60, 2);
    for (int i = 0; i < 6; i++)
      check("R6", $sformatf("next descriptor byte %0d", i), {24'd0, mbyte(32'h800 + i)}, 32'h60 + i);
    check("R9", "error frame writeback", mem[(BASE >> 2) + 4], 32'h0006_8100);
  endtask

  task automatic t_overflow();
    send_frame(7, 8'hA0, -1);
    for (int i = 0; i < 4; i++)
      check("R10", $sformatf("stored byte %0d", i), {24'd0, mbyte(32'hC00 + i)}, 32'hA0 + i);
    for (int i = 4; i < 7; i++)
      check("R10", $sformatf("discarded byte %0d", i), {24'd0, mbyte(32'hC00 + i)}, 32'hEE);
    check("R10", "overflow writeback", mem[(BASE >> 2) + 8], 32'h0004_8100);
  endtask

  task automatic t_drop_and_wrap();
    logic [31:0] d;
    int w0;
    w0 = wr_cnt;
    send_frame(5, 8'hC0, -1);
    check("R8", "no writes on drop", wr_cnt, w0);
    check("R8", "descriptor untouched", mem[BASE >> 2], 32'h000A_0100);
    csr_read(2'd3, d);
    check("R8", "missed flag set", {31'd0, d[16]}, 32'h1);
    put_desc(0, 1, 0, 64, 32'h500);
    send_frame(5, 8'hD0, -1);
    for (int i = 0; i < 5; i++)
      check("R7", $sformatf("wrapped frame byte %0d", i), {24'd0, mbyte(32'h500 + i)}, 32'hD0 + i);
    check("R7", "wrapped writeback", mem[BASE >> 2], 32'h0005_0100);
    check("R6", "second descriptor not reused", mem[(BASE >> 2) + 4], 32'h0006_8100);
    csr_read(2'd3, d);
    check("R8", "missed flag sticky", {31'd0, d[16]}, 32'h1);
  endtask

  task automatic t_stop_and_reset();
    logic [31:0] d;
    csr_write(2'd1, 32'h0);
    csr_read(2'd3, d);
    check("R2", "state after stop", {29'd0, d[19:17]}, 32'h0);
    csr_write(2'd1, 32'h2);
    csr_write(2'd0, 32'h1);
    csr_read(2'd0, d);
    check("R11", "reset bit reads zero", d, 32'h0);
    csr_read(2'd1, d);
    check("R11", "enable cleared", d, 32'h0);
    csr_read(2'd2, d);
    check("R11", "base cleared", d, 32'h0);
    csr_read(2'd3, d);
    check("R11", "status cleared", d, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hEEEE_EEEE;
    put_desc(0, 1, 0, 64, 32'h402);
    put_desc(1, 1, 0, 64, 32'h800);
    put_desc(2, 1, 1, 4, 32'hC00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    csr_write(2'd2, BASE);
    t_stopped();
    t_enable();
    t_basic();
    t_error();
    t_overflow();
    t_drop_and_wrap();
    t_stop_and_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule